// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked on-chip request port to an external asynchronous static RAM. The RAM has a 16-bit address, a 16-bit data bus split into two byte lanes with their own active-low enables, and active-low select, output-enable and write-enable strobes. A user issues one request at a time: an address, a write flag, a per-lane byte mask and, for writes, the write data. The controller answers with a one-clock done pulse. For reads it also returns the captured data.

All RAM timing is produced by wait-state counts. Each count is derived at elaboration from the clock period and the RAM's minimum times, rounding up and never below one clock. The defaults are a 20 ns clock, a 70 ns read and write cycle, a 55 ns write pulse and 30 ns of data setup. With these values a read holds output enable low for 4 clocks, and a write runs a 1-clock setup phase, a 3-clock write-enable pulse and a 1-clock recovery phase.

Writes are controlled by the write-enable strobe. Output enable stays high for the whole write, so the pulse never has to cover the bus turnaround. The address and lane enables are loaded when a request is accepted and do not move while the chip is selected. The controller drives the data bus only while write enable is low.

Top module: `sram_byte_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, chip select, output enable and write enable are high, the data-bus drive enable is low, busy and done are low, and no request is in progress.
- R2: A request (req_valid high) is taken only in a clock where the controller is idle. Busy is high from the clock after acceptance until done rises, when busy falls. Requests presented while busy are ignored and cause no RAM access.
- R3: A read holds chip select and output enable low and write enable high for RD_CYC clocks. RD_CYC is ceil(max(access time, read cycle)/clock) with a minimum of 1, which is 4 with the defaults. Done pulses for one clock in the clock after the strobes rise, RD_CYC+1 clocks after the request was presented.
- R4: Byte mask bit 0 selects the low lane (data bits 7:0) and drives mem_be_n[0] low. Mask bit 1 selects the high lane (bits 15:8) and drives mem_be_n[1] low. In read data, lanes that were not selected return zero.
- R5: A write has three phases with output enable high throughout: a 1-clock setup phase with chip select low and write enable high, then write enable low for WP_CYC = ceil(max(write pulse, data setup)/clock) clocks (3 with the defaults), then recovery phases with write enable high that bring the select time to at least the write cycle. With the defaults, chip select is low for 5 clocks and done arrives 6 clocks after the request.
- R6: A write changes only the RAM byte lanes whose mask bits are set. The other lanes keep their contents.
- R7: The data-bus drive enable is high only while chip select and write enable are both low, and the write data stays driven for the whole write-enable pulse.
- R8: Address and byte-lane enables are loaded at acceptance and stay constant for every clock in which chip select is low. The address on the RAM port equals the requested address.
- R9: A request with mask 00 runs a normal-length cycle with both lane enables high. A write with mask 00 changes no RAM data, and a read with mask 00 returns zero.
- R10: Read data changes only when a read completes and is held unchanged across idle clocks and across following write requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | LANES | Byte-lane mask, bit 0 = low lane |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Last read result |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_be_n | output | LANES | RAM byte-lane enables, active low, bit 0 = low lane |
| mem_dq_out | output | DATA_W | Data to the RAM bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the RAM bus |

## Verification
A wrong internal state shows at the ports as soon as the next request runs. A phase counter that is off by one changes the number of clocks with output enable or write enable low, and it moves done away from its fixed latency on the same transaction. A lane mask that is latched wrongly corrupts the neighbouring byte in the RAM model. That corruption stays silent until a later read of that word, so the sweep reads every written word back under all four masks. Bus drive outside the write pulse, or an address moving during a select, is flagged on the clock where it happens.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } ctrl_state_t;

  // Round a time up to whole clocks, never less than one.
  function automatic int unsigned ns_to_clk(input int unsigned t_ns,
                                            input int unsigned clk_ns);
    int unsigned r;
    r = (t_ns + clk_ns - 1) / clk_ns;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             active,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] be_n
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_n[l] = ~(active & mask[l]);
  end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int unsigned LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*8-1:0] dq_in,
  output logic [LANES*8-1:0] rd_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[l*8 +: 8] <= '0;
      end else if (cap) begin
        rd_data[l*8 +: 8] <= mask[l] ? dq_in[l*8 +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned T_RC   = 70,
  parameter int unsigned T_AA   = 70,
  parameter int unsigned T_WC   = 70,
  parameter int unsigned T_WP   = 55,
  parameter int unsigned T_DW   = 30,
  parameter int unsigned T_AS   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W/8-1:0]     req_be,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rd_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_cs_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [DATA_W/8-1:0]     mem_be_n,
  output logic [DATA_W-1:0]       mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [DATA_W-1:0]       mem_dq_in
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned RD_CYC   = ns_to_clk(umax(T_AA, T_RC), CLK_NS);
  localparam int unsigned SU_CYC   = ns_to_clk(T_AS, CLK_NS);
  localparam int unsigned WP_CYC   = ns_to_clk(umax(T_WP, T_DW), CLK_NS);
  localparam int unsigned WC_CYC   = ns_to_clk(T_WC, CLK_NS);
  localparam int unsigned REC_CYC  = (WC_CYC > SU_CYC + WP_CYC + 1) ?
                                     (WC_CYC - SU_CYC - WP_CYC) : 1;
  localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, SU_CYC),
                                          umax(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_state_t       state, nxt;
  logic              accept;
  logic              cap;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_len;
  logic              tmr_last;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  mask_sel;
  logic [LANES-1:0]  be_n_nxt;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .last (tmr_last)
  );

  // Next-state and phase-length selection
  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    cap      = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            nxt     = ST_WSETUP;
            tmr_len = CNT_W'(SU_CYC);
          end else begin
            nxt     = ST_RD;
            tmr_len = CNT_W'(RD_CYC);
          end
        end
      end
      ST_RD: begin
        if (tmr_last) begin
          cap = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        if (tmr_last) begin
          nxt      = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(WP_CYC);
        end
      end
      ST_WPULSE: begin
        if (tmr_last) begin
          nxt      = ST_WREC;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(REC_CYC);
        end
      end
      ST_WREC: begin
        if (tmr_last) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign mask_sel = accept ? req_be : mask_q;

  sram_lane_decode #(.LANES(LANES)) u_lanes (
    .active (nxt != ST_IDLE),
    .mask   (mask_sel),
    .be_n   (be_n_nxt)
  );

  // All RAM-facing outputs are registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_be_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mask_q     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= nxt;
      mem_cs_n   <= (nxt == ST_IDLE);
      mem_oe_n   <= (nxt != ST_RD);
      mem_we_n   <= (nxt != ST_WPULSE);
      mem_dq_oe  <= (nxt == ST_WPULSE);
      mem_be_n   <= be_n_nxt;
      busy       <= (nxt != ST_IDLE);
      done       <= (state != ST_IDLE) && (nxt == ST_IDLE);
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
        mask_q     <= req_be;
      end
    end
  end

  sram_read_capture #(.LANES(LANES)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .mask    (mask_q),
    .dq_in   (mem_dq_in),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned WP_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be_n
);

  logic [15:0] we_run;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && !done));

  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_select_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> busy);

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_oe_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));

  p_drive_in_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  // Write pulse length measured with a counter
  always_ff @(posedge clk) begin
    if (rst) we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 16'd1;
    else we_run <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst && mem_we_n && we_run != '0) begin
      p_pulse_len_r5: assert (we_run == 16'(WP_CYC));
    end
  end

endmodule

bind sram_byte_ctrl sram_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr),
  .mem_be_n  (mem_be_n)
);

// File: tb/test_sram_byte_ctrl.sv
module test_sram_byte_ctrl;

  localparam int RD_LAT = 5;   // RD_CYC 4 + done clock
  localparam int WR_LAT = 6;   // 1 + 3 + 1 + done clock
  localparam logic [15:0] BASE = 16'h5A00;
  localparam int NADDR = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done;
  logic [15:0] rd_data, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] model [256];
  logic [15:0] shadow [256];

  int mon_cs, mon_oe, mon_we, bad_drive, bad_addr;
  logic [15:0] seen_addr;
  logic [1:0]  seen_be;
  logic        prev_cs_low;
  logic [15:0] prev_addr;

  sram_byte_ctrl i_sram_byte_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always #10 clk = ~clk;

  // Behavioural RAM: read data only while selected with output enable low
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ?
    {mem_be_n[1] ? 8'hEE : model[mem_addr[7:0]][15:8],
     mem_be_n[0] ? 8'hEE : model[mem_addr[7:0]][7:0]} : 16'hDEAD;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n) begin
        mon_cs++;
        seen_addr = mem_addr;
        seen_be = mem_be_n;
        if (prev_cs_low && mem_addr != prev_addr) bad_addr++;
      end
      if (!mem_oe_n) mon_oe++;
      if (!mem_we_n) mon_we++;
      if (mem_dq_oe && (mem_we_n || mem_cs_n)) bad_drive++;
      if (!mem_cs_n && !mem_we_n) begin
        if (!mem_dq_oe) bad_drive++;
        for (int l = 0; l < 2; l++)
          if (!mem_be_n[l]) model[mem_addr[7:0]][l*8 +: 8] = mem_dq_out[l*8 +: 8];
      end
      prev_cs_low = !mem_cs_n;
      prev_addr = mem_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [15:0] a, input logic [1:0] m,
                        input logic [15:0] d, input bit inject,
                        output logic [15:0] rdat);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = m; req_wdata = d;
    mon_cs = 0; mon_oe = 0; mon_we = 0;
    @(negedge clk);
    lat = 1;
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    if (inject) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0011;
      req_be = 2'b11; req_wdata = 16'hFFFF;
    end
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == 2) req_valid = 1'b0;
    end
    chk(lat == (wr ? WR_LAT : RD_LAT), wr ? "R5 write latency" : "R3 read latency",
        lat, wr ? WR_LAT : RD_LAT);
    chk(busy == 1'b0, "R2 busy low at done", busy, 0);
    chk(seen_addr == a, "R8 address on port", seen_addr, a);
    chk(seen_be == ~m, "R4 lane enables", seen_be, ~m);
    if (wr) begin
      chk(mon_we == 3, "R5 write pulse clocks", mon_we, 3);
      chk(mon_oe == 0, "R5 output enable high in write", mon_oe, 0);
      chk(mon_cs == 5, "R5 select clocks in write", mon_cs, 5);
      for (int l = 0; l < 2; l++)
        if (m[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    end else begin
      chk(mon_oe == 4, "R3 output enable clocks", mon_oe, 4);
      chk(mon_cs == 4, "R3 select clocks", mon_cs, 4);
      chk(mon_we == 0, "R3 write enable high in read", mon_we, 0);
    end
    rdat = rd_data;
    @(negedge clk);
    chk(done == 1'b0, "R3 done one clock", done, 0);
  endtask

  function automatic logic [15:0] lane_exp(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  initial begin
    logic [15:0] r, held;
    for (int i = 0; i < 256; i++) begin model[i] = '0; shadow[i] = '0; end
    mon_cs = 0; mon_oe = 0; mon_we = 0; bad_drive = 0; bad_addr = 0;
    prev_cs_low = 1'b0; prev_addr = '0; seen_addr = '0; seen_be = '0;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_oe && !busy && !done, "R1 bus released and idle",
        {mem_dq_oe, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && !busy, "R1 idle after reset", {mem_cs_n, busy}, 2'b10);

    // Full-word writes to every address
    for (int a = 0; a < NADDR; a++)
      do_req(1'b1, BASE + 16'(a), 2'b11, 16'((a * 37 + 5) * 259), 1'b0, r);
    // Partial writes, mask cycles through 00, 01, 10, 11 (R6, R9)
    for (int a = 0; a < NADDR; a++)
      do_req(1'b1, BASE + 16'(a), 2'(a % 4), 16'(a * 4099 + 16'h1234), 1'b0, r);
    // Read back under every mask (R4, R6, R9)
    for (int a = 0; a < NADDR; a++)
      for (int m = 0; m < 4; m++) begin
        do_req(1'b0, BASE + 16'(a), 2'(m), 16'h0, 1'b0, r);
        chk(r == lane_exp(shadow[a], 2'(m)),
            (m == 0) ? "R9 empty mask reads zero" : "R6 R4 read data", r,
            lane_exp(shadow[a], 2'(m)));
      end

    // R10: read data held over idle clocks and a later write
    do_req(1'b0, BASE + 16'd7, 2'b11, 16'h0, 1'b0, held);
    repeat (5) @(negedge clk);
    chk(rd_data == held, "R10 held while idle", rd_data, held);
    do_req(1'b1, BASE + 16'd9, 2'b01, 16'hBEEF, 1'b0, r);
    chk(rd_data == held, "R10 held across write", rd_data, held);

    // R2: a request during busy is ignored
    do_req(1'b1, BASE + 16'd5, 2'b11, 16'h0A5A, 1'b1, r);
    chk(mem_cs_n && !busy, "R2 idle after ignored request", {mem_cs_n, busy}, 2'b10);
    do_req(1'b0, BASE + 16'd5 ^ 16'h0011, 2'b11, 16'h0, 1'b0, r);
    chk(r == shadow[8'h14], "R2 injected write absent", r, shadow[8'h14]);
    do_req(1'b0, BASE + 16'd5, 2'b11, 16'h0, 1'b0, r);
    chk(r == 16'h0A5A, "R6 word after ignored request", r, 16'h0A5A);

    chk(bad_drive == 0, "R7 bus drive only in write pulse", bad_drive, 0);
    chk(bad_addr == 0, "R8 address stable while selected", bad_addr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule